// File: doc/BRIEF.md
# SD SPI Single-Block Data Transfer Engine

This block moves one data block between a local byte buffer and a memory card on an SPI link, once the card has already accepted a read or write command. It never issues commands itself. Instead it drives a byte-wide SPI shifter through a request/acknowledge handshake and sequences the bytes that make up the data phase of a single-block transfer.

For a read, the engine polls with fill bytes until the card's start token appears. It stores the following N bytes into the buffer and then clocks two check bytes, which it discards. For a write, it sends the start token, fetches N bytes from the buffer and sends them, then sends two dummy check bytes. After that it decodes the card's data response byte and waits out the busy period.

Every transfer ends with one trailing byte clocked while chip select is high, followed by a one-cycle done pulse. A poll limit on both the token hunt and the busy wait turns an absent or stuck card into an error instead of a hang.

Top module: `sdblk_xfer`

## Requirements
- R1: After reset, `cs_n_o` is 1, and `spi_req_o`, `buf_rd_o`, `buf_we_o` and `done_o` are 0.
- R2: Once raised, `spi_req_o` stays high with `spi_tx_o` unchanged until `spi_ack_i` is seen. `spi_rx_i` is taken in that acknowledge cycle, and each acknowledged request is one byte on the link.
- R3: A read (start with `wr_i`=0) sends 0xFF bytes until a received byte equals 0xFE. Bytes received before that token are never written to the buffer.
- R4: After the token, a read sends N more 0xFF bytes and writes each received byte to the buffer, at addresses 0 to N-1 in arrival order. N is the value of `len_i` at start, with 1 ≤ N ≤ MAX_LEN; both 16 and 512 are supported.
- R5: After its data, a read clocks two more 0xFF bytes and does not store what comes back.
- R6: A write (start with `wr_i`=1) sends 0xFE, then the buffer bytes at addresses 0 to N-1 in order (read through `buf_rd_o`), then two 0xFF bytes.
- R7: A write then sends one 0xFF byte and captures the reply. If reply[4:0] is 0x05 the write is accepted. Otherwise the transfer ends with error and skips the busy wait. In both cases `wr_status_o` = reply[3:1] (010 accepted, 101 check error, 110 write error).
- R8: After acceptance, the engine sends 0xFF bytes while the received byte is 0x00 and stops polling at the first nonzero byte.
- R9: Every transfer ends with exactly one 0xFF byte sent with `cs_n_o`=1; `cs_n_o` is 0 for all earlier bytes. `done_o` then pulses for one cycle. `err_o` is valid from that pulse and holds until the next accepted start.
- R10: If TMO_POLLS polls fail in a row, in either the token hunt or the busy wait, the transfer ends with `err_o`=1.
- R11: `start_i` has no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| wr_i | input | 1 | Direction: 1 write to card, 0 read from card |
| len_i | input | LEN_W | Block length in bytes, sampled at start |
| spi_req_o | output | 1 | Byte request to the SPI shifter |
| spi_tx_o | output | 8 | Byte to shift out |
| spi_ack_i | input | 1 | Shifter finished the requested byte |
| spi_rx_i | input | 8 | Byte shifted in, valid with `spi_ack_i` |
| cs_n_o | output | 1 | Card chip select, active low |
| buf_rd_o | output | 1 | Buffer read strobe (write direction) |
| buf_we_o | output | 1 | Buffer write strobe (read direction) |
| buf_addr_o | output | AW | Buffer byte address |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, same cycle as `buf_rd_o` |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Transfer failed |
| wr_status_o | output | 3 | Decoded write response status |

## Verification
Reads are run with the token arriving at once, after fill bytes, and after non-token junk bytes. This separates correct token hunting from storing bytes too early. Lengths 16 and 512 show that the length is taken from the start-time input and that addressing spans the whole block. Writes are run with an accepted reply that has junk upper bits, with the check-error and write-error replies, and with busy periods of several lengths, which separates masking, status decoding and busy tracking. A card that never answers, a busy that never ends, and a start pulse during a transfer exercise the poll limit and the ignore rule.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HUNT, ST_RDAT, ST_RCRC, ST_WTOK,
    ST_WDAT, ST_WCRC, ST_WRSP, ST_BUSY, ST_TAIL
  } sdblk_st_e;

  localparam logic [7:0] TOK_START = 8'hFE;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [4:0] RSP_MASKED_OK = 5'h05;
endpackage

// File: rtl/sdblk_cnt.sv
module sdblk_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign val_o  = cnt_q;
  assign last_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/sdblk_txsel.sv
module sdblk_txsel
  import sdblk_pkg::*;
(
  input  sdblk_st_e  st_i,
  input  logic [7:0] buf_rdata_i,
  output logic [7:0] tx_o
);
  always_comb begin
    case (st_i)
      ST_WTOK: tx_o = TOK_START;
      ST_WDAT: tx_o = buf_rdata_i;
      default: tx_o = FILL_BYTE;
    endcase
  end
endmodule

// File: rtl/sdblk_xfer.sv
module sdblk_xfer
  import sdblk_pkg::*;
#(
  parameter int MAX_LEN   = 512,
  parameter int TMO_POLLS = 256,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int AW       = $clog2(MAX_LEN),
  localparam int TW       = $clog2(TMO_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             spi_req_o,
  output logic [7:0]       spi_tx_o,
  input  logic             spi_ack_i,
  input  logic [7:0]       spi_rx_i,
  output logic             cs_n_o,
  output logic             buf_rd_o,
  output logic             buf_we_o,
  output logic [AW-1:0]    buf_addr_o,
  output logic [7:0]       buf_wdata_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       wr_status_o
);
  localparam logic [TW-1:0] TMO_LIM = TW'(TMO_POLLS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  sdblk_st_e        st_q, st_d;
  logic             fly_q, fly_d;
  logic [7:0]       tx_q, tx_sel;
  logic [LEN_W-1:0] len_q;
  logic             err_q, err_d, err_out_q;
  logic [2:0]       wst_q, wst_d;
  logic             we_q, we_d;
  logic [7:0]       wdat_q;
  logic [AW-1:0]    wa_q;
  logic             done_q, fin;
  logic             accept, ack, issue;
  logic             idx_clr, idx_inc, idx_last;
  logic [LEN_W-1:0] idx_val;
  logic             wd_clr, wd_inc, wd_last;
  logic [TW-1:0]    wd_val;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign ack    = fly_q && spi_ack_i;
  assign issue  = (st_q != ST_IDLE) && !fly_q;

  sdblk_cnt #(.W(LEN_W)) idx_i (
    .clk(clk), .rst_n(rst_sn), .clr_i(idx_clr), .inc_i(idx_inc),
    .lim_i(len_q), .val_o(idx_val), .last_o(idx_last)
  );

  sdblk_cnt #(.W(TW)) wdog_i (
    .clk(clk), .rst_n(rst_sn), .clr_i(wd_clr), .inc_i(wd_inc),
    .lim_i(TMO_LIM), .val_o(wd_val), .last_o(wd_last)
  );

  sdblk_txsel txsel_i (.st_i(st_q), .buf_rdata_i(buf_rdata_i), .tx_o(tx_sel));

  // next-state logic
  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    wst_d   = wst_q;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    wd_clr  = 1'b0;
    wd_inc  = 1'b0;
    we_d    = 1'b0;
    fin     = 1'b0;
    if (accept) begin
      err_d   = 1'b0;
      wst_d   = 3'b000;
      idx_clr = 1'b1;
      wd_clr  = 1'b1;
      st_d    = wr_i ? ST_WTOK : ST_HUNT;
    end else if (ack) begin
      case (st_q)
        ST_HUNT: begin
          if (spi_rx_i == TOK_START) begin
            st_d = ST_RDAT;
            idx_clr = 1'b1;
          end else if (wd_last) begin
            err_d = 1'b1;
            st_d  = ST_TAIL;
          end else wd_inc = 1'b1;
        end
        ST_RDAT: begin
          we_d = 1'b1;
          if (idx_last) begin
            st_d = ST_RCRC;
            idx_clr = 1'b1;
          end else idx_inc = 1'b1;
        end
        ST_RCRC: begin
          if (idx_val != '0) st_d = ST_TAIL;
          else               idx_inc = 1'b1;
        end
        ST_WTOK: st_d = ST_WDAT;
        ST_WDAT: begin
          if (idx_last) begin
            st_d = ST_WCRC;
            idx_clr = 1'b1;
          end else idx_inc = 1'b1;
        end
        ST_WCRC: begin
          if (idx_val != '0) st_d = ST_WRSP;
          else               idx_inc = 1'b1;
        end
        ST_WRSP: begin
          wst_d = spi_rx_i[3:1];
          if (spi_rx_i[4:0] == RSP_MASKED_OK) begin
            st_d   = ST_BUSY;
            wd_clr = 1'b1;
          end else begin
            err_d = 1'b1;
            st_d  = ST_TAIL;
          end
        end
        ST_BUSY: begin
          if (spi_rx_i != 8'h00) st_d = ST_TAIL;
          else if (wd_last) begin
            err_d = 1'b1;
            st_d  = ST_TAIL;
          end else wd_inc = 1'b1;
        end
        ST_TAIL: begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fly_d = fly_q;
    if (issue)    fly_d = 1'b1;
    else if (ack) fly_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q      <= ST_IDLE;
      fly_q     <= 1'b0;
      tx_q      <= FILL_BYTE;
      len_q     <= '0;
      err_q     <= 1'b0;
      err_out_q <= 1'b0;
      wst_q     <= 3'b000;
      we_q      <= 1'b0;
      wdat_q    <= 8'h00;
      wa_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      fly_q  <= fly_d;
      err_q  <= err_d;
      wst_q  <= wst_d;
      we_q   <= we_d;
      done_q <= fin;
      if (issue)  tx_q  <= tx_sel;
      if (accept) len_q <= len_i;
      if (accept)   err_out_q <= 1'b0;
      else if (fin) err_out_q <= err_q;
      if (we_d) begin
        wdat_q <= spi_rx_i;
        wa_q   <= idx_val[AW-1:0];
      end
    end
  end

  assign spi_req_o   = fly_q;
  assign spi_tx_o    = tx_q;
  assign cs_n_o      = (st_q == ST_IDLE) || (st_q == ST_TAIL);
  assign buf_rd_o    = issue && (st_q == ST_WDAT);
  assign buf_we_o    = we_q;
  assign buf_wdata_o = wdat_q;
  assign buf_addr_o  = we_q ? wa_q : idx_val[AW-1:0];
  assign done_o      = done_q;
  assign err_o       = err_out_q;
  assign wr_status_o = wst_q;
endmodule

// File: rtl/sdblk_xfer_chk.sv
module sdblk_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_req_o,
  input logic       spi_ack_i,
  input logic [7:0] spi_tx_o,
  input logic       cs_n_o,
  input logic       buf_rd_o,
  input logic       buf_we_o,
  input logic       done_o,
  input logic       err_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req_o && !spi_ack_i |=> spi_req_o && $stable(spi_tx_o)); // R2
  AST_DONE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o && !spi_req_o); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o); // R9
  AST_WE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> $past(spi_req_o && spi_ack_i)); // R4
  AST_RD_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |-> !cs_n_o && !buf_we_o); // R6
endmodule

bind sdblk_xfer sdblk_xfer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_req_o(spi_req_o), .spi_ack_i(spi_ack_i),
  .spi_tx_o(spi_tx_o), .cs_n_o(cs_n_o), .buf_rd_o(buf_rd_o),
  .buf_we_o(buf_we_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sdblk_xfer_tb.sv
`timescale 1ns/1ps
module sdblk_xfer_tb_top;
  localparam int MAX_LEN = 512;
  localparam int TMO     = 256;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int AW      = $clog2(MAX_LEN);

  logic clk = 1'b0;
  logic rst_n;
  logic start, wr;
  logic [LEN_W-1:0] len;
  logic spi_req, spi_ack;
  logic [7:0] spi_tx, spi_rx;
  logic cs_n, buf_rd, buf_we, done, err;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata;
  logic [2:0] wst;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bufpat(input int a);
    return 8'((a * 3) ^ 8'h5A);
  endfunction
  assign buf_rdata = bufpat(int'(buf_addr));

  sdblk_xfer #(.MAX_LEN(MAX_LEN), .TMO_POLLS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wr_i(wr), .len_i(len),
    .spi_req_o(spi_req), .spi_tx_o(spi_tx), .spi_ack_i(spi_ack), .spi_rx_i(spi_rx),
    .cs_n_o(cs_n), .buf_rd_o(buf_rd), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata), .done_o(done), .err_o(err),
    .wr_status_o(wst)
  );

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  logic [7:0]  card_q[$];   // bytes the card returns
  logic [8:0]  exp_tx[$];   // {cs_n, byte} expected on the link
  logic [31:0] exp_wr[$];   // {addr, data} expected buffer writes
  string       tag = "R3";  // requirement of the current stream

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
    end
  endtask

  // card model and scoreboard monitor
  int lat = 0;
  initial begin
    spi_ack = 1'b0;
    spi_rx  = 8'hFF;
    forever begin
      @(negedge clk);
      if (buf_we) begin
        if (exp_wr.size() == 0) chk(0, "R3", "unexpected buffer write", int'(buf_addr), -1);
        else begin
          logic [31:0] e;
          e = exp_wr.pop_front();
          chk({buf_addr, buf_wdata} == e[AW+7:0], "R4", "buffer write {addr,data}",
              int'({buf_addr, buf_wdata}), int'(e[AW+7:0]));
        end
      end
      if (done) done_cnt++;
      if (spi_ack) begin
        spi_ack = 1'b0;
        lat = 0;
      end else if (spi_req) begin
        lat++;
        if (lat == 2) begin
          if (exp_tx.size() == 0) chk(0, tag, "unexpected link byte", int'(spi_tx), -1);
          else begin
            logic [8:0] e;
            e = exp_tx.pop_front();
            chk({cs_n, spi_tx} == e, tag, "link {cs_n,tx}", int'({cs_n, spi_tx}), int'(e));
          end
          spi_rx  = (card_q.size() != 0) ? card_q.pop_front() : 8'hFF;
          spi_ack = 1'b1;
        end
      end
    end
  end

  task automatic pulse_start(input logic w, input int n);
    @(negedge clk);
    start = 1'b1; wr = w; len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_xfer(input string r, input logic e_err, input logic [2:0] e_wst);
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R9", "done pulse", int'(done), 1);
    chk(err == e_err, r, "err", int'(err), int'(e_err));
    chk(wst == e_wst, "R7", "wr_status", int'(wst), int'(e_wst));
    @(negedge clk);
    chk(!done, "R9", "done one cycle", int'(done), 0);
    chk(exp_tx.size() == 0 && card_q.size() == 0, "R9", "stream fully consumed",
        exp_tx.size(), 0);
    chk(exp_wr.size() == 0, "R4", "all buffer writes seen", exp_wr.size(), 0);
  endtask

  task automatic push_ff(input int n, input logic c);
    for (int i = 0; i < n; i++) exp_tx.push_back({c, 8'hFF});
  endtask

  task automatic do_read(input int n, input int npre, input logic [7:0] preb, input int seed);
    for (int i = 0; i < npre; i++) card_q.push_back(preb);
    card_q.push_back(8'hFE);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((i * 13 + seed) ^ (i >> 3));
      card_q.push_back(d);
      exp_wr.push_back(32'((i << 8) | d));
    end
    card_q.push_back(8'h3C);   // check bytes, discarded (R5)
    card_q.push_back(8'hFE);
    push_ff(npre + 1 + n + 2, 1'b0);
    push_ff(1, 1'b1);          // R9 trailing byte
    pulse_start(1'b0, n);
  endtask

  task automatic do_write(input int n, input logic [7:0] rsp, input int nbusy, input bit stuck);
    exp_tx.push_back({1'b0, 8'hFE});
    for (int i = 0; i < n; i++) exp_tx.push_back({1'b0, bufpat(i)});
    push_ff(3, 1'b0);
    for (int i = 0; i < n + 3; i++) card_q.push_back(8'hFF);
    card_q.push_back(rsp);
    if (rsp[4:0] == 5'h05) begin
      for (int i = 0; i < nbusy; i++) card_q.push_back(8'h00);
      push_ff(nbusy, 1'b0);
      if (!stuck) begin
        card_q.push_back(8'h01);
        push_ff(1, 1'b0);
      end
    end
    push_ff(1, 1'b1);
    pulse_start(1'b1, n);
  endtask

  initial begin
    start = 1'b0; wr = 1'b0; len = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    chk(!spi_req && !buf_rd && !buf_we && !done, "R1", "outputs quiet in reset",
        int'({spi_req, buf_rd, buf_we, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && !spi_req && !done, "R1", "idle after reset",
        int'({cs_n, spi_req, done}), 4);

    tag = "R3"; do_read(16, 3, 8'hFF, 7);     finish_xfer("R4", 1'b0, 3'b000);
    tag = "R3"; do_read(16, 5, 8'h12, 99);    finish_xfer("R3", 1'b0, 3'b000);
    tag = "R4"; do_read(512, 0, 8'hFF, 41);   finish_xfer("R4", 1'b0, 3'b000);
    tag = "R6"; do_write(16, 8'hE5, 3, 0);    finish_xfer("R8", 1'b0, 3'b010);
    tag = "R8"; do_write(512, 8'h05, 0, 0);   finish_xfer("R8", 1'b0, 3'b010);
    tag = "R7"; do_write(16, 8'h0B, 0, 0);    finish_xfer("R7", 1'b1, 3'b101);
    tag = "R7"; do_write(16, 8'h0D, 0, 0);    finish_xfer("R7", 1'b1, 3'b110);
    // R10: card never sends the token
    tag = "R10"; push_ff(TMO, 1'b0); push_ff(1, 1'b1); pulse_start(1'b0, 16);
    finish_xfer("R10", 1'b1, 3'b000);
    tag = "R10"; do_write(16, 8'h05, TMO, 1); finish_xfer("R10", 1'b1, 3'b010);
    // R9: err clears on the next start
    tag = "R3"; do_read(16, 0, 8'hFF, 3);
    @(negedge clk);
    chk(!err, "R9", "err cleared by new start", int'(err), 0);
    finish_xfer("R4", 1'b0, 3'b000);
    // R11: start pulse during a read is ignored
    begin
      int d0;
      d0 = done_cnt;
      tag = "R11";
      fork
        do_read(16, 2, 8'hFF, 55);
        begin
          repeat (30) @(negedge clk);
          start = 1'b1; wr = 1'b1; len = LEN_W'(5);
          @(negedge clk);
          start = 1'b0;
        end
      join
      finish_xfer("R11", 1'b0, 3'b000);
      repeat (20) @(negedge clk);
      chk(done_cnt - d0 == 1, "R11", "one done for one transfer", done_cnt - d0, 1);
      chk(!spi_req && cs_n, "R11", "link idle after ignored start",
          int'({spi_req, cs_n}), 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule